// File: doc/BRIEF.md
# Triple-Redundancy Voter with Module and Comparator Diagnosis

This block sits after three redundant copies of a logic module that receive the same inputs. On every cycle where the valid strobe is high it forms the bit-by-bit two-of-three majority of the three result words and passes that word on as the protected result. It also compares the words in pairs and reads the pattern of the three mismatch flags. From that pattern it reports whether everything agrees, which single module has drifted away from the other two, which single comparator has failed, or whether the disagreement cannot be attributed to one source.

A failing comparator shows up as a single raised flag, because a real data disagreement always disturbs two of the three pairs. The diagnosis logic is a separate unit that is driven only by the three flags, so it treats a stuck comparator output the same way it treats a real data pattern. All results are registered and appear one cycle after the valid strobe. While the strobe is low the registered results hold their last value and the output valid drops.

Top module: `tmr_voter_diag`

## Requirements
- R1: `mismatch` bit 0 compares module A with B, bit 1 compares A with C, and bit 2 compares B with C. Each bit is 1 exactly when its two words differ in any bit.
- R2: `voted` is, bit by bit, the value that at least two of the three input words carry at that position.
- R3: When two words agree and the third differs, `bad_module` is one-hot on the odd word (bit 0 = A, bit 1 = B, bit 2 = C), and `bad_cmp` and `multi_err` are 0.
- R4: When the diagnosis unit sees exactly one raised mismatch flag, `bad_cmp` is one-hot at that flag's position, and `bad_module` and `multi_err` are 0.
- R5: When all three mismatch flags are raised, `multi_err` is 1 and `bad_module` and `bad_cmp` are 0.
- R6: When all three words are equal, all mismatch and fault indications are 0 and `voted` equals the common word.
- R7: The results for the inputs sampled with `in_valid` high appear after that clock edge. `out_valid` is 1 in exactly the cycle that follows a cycle in which `in_valid` was high.
- R8: A cycle with `in_valid` low sets `out_valid` to 0 and leaves `voted`, `mismatch`, `bad_module`, `bad_cmp` and `multi_err` unchanged, whatever the data inputs do.
- R9: A synchronous reset (`rst` high at a clock edge) clears every output to 0.
- R10: `bad_module` has at most one bit set. At most one of the three classes (module fault, comparator fault, multiple error) is reported in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The three words are valid this cycle |
| mod_a | input | W | Result word of redundant module A |
| mod_b | input | W | Result word of redundant module B |
| mod_c | input | W | Result word of redundant module C |
| out_valid | output | 1 | Registered results are fresh this cycle |
| voted | output | W | Registered majority word |
| mismatch | output | 3 | Registered pairwise mismatch flags {B/C, A/C, A/B} |
| bad_module | output | 3 | One-hot faulty module {C, B, A} |
| bad_cmp | output | 3 | One-hot faulty comparator, same positions as `mismatch` |
| multi_err | output | 1 | Disagreement that no single fault explains |

## Verification
On every clock the assertions check the one-cycle valid latency, the holding of results on idle cycles, the exclusivity of the fault classes, the one-hot module report, and the agreement between the registered flags and the blame they produce. The per-bit majority, the pairwise flags and the module diagnosis are checked only by the bench, which sweeps every combination of three 4-bit words. The comparator-fault decode cannot be reached from consistent data, so the bench drives the diagnosis unit on its own over all eight flag patterns.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;
  // Comparator slot assignment; the diagnosis unit depends on this order.
  localparam int unsigned SLOT_AB = 0;
  localparam int unsigned SLOT_AC = 1;
  localparam int unsigned SLOT_BC = 2;
  localparam int unsigned NUM_MOD = 3;

  // Module index positions inside bad_module
  localparam int unsigned MOD_A = 0;
  localparam int unsigned MOD_B = 1;
  localparam int unsigned MOD_C = 2;

  typedef enum logic [1:0] {
    DX_CLEAN  = 2'd0,
    DX_MODULE = 2'd1,
    DX_COMPAR = 2'd2,
    DX_MULTI  = 2'd3
  } diag_class_e;

  // Two-of-three vote of one bit position
  function automatic logic vote_bit(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  // Classify a mismatch pattern by how many flags are raised
  function automatic diag_class_e classify(input logic [2:0] flags);
    unique case ($countones(flags))
      0:       return DX_CLEAN;
      1:       return DX_COMPAR;
      2:       return DX_MODULE;
      default: return DX_MULTI;
    endcase
  endfunction

  // The module common to two raised flags is the one missing from the quiet pair
  function automatic logic [2:0] odd_module(input logic [2:0] flags);
    logic [2:0] m;
    m = '0;
    if (!flags[SLOT_BC]) m[MOD_A] = 1'b1;
    else if (!flags[SLOT_AC]) m[MOD_B] = 1'b1;
    else if (!flags[SLOT_AB]) m[MOD_C] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tmr_pair_cmp.sv
module tmr_pair_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic         differ
);
  logic [W-1:0] bit_diff;
  assign bit_diff = x ^ y;
  assign differ   = |bit_diff;
endmodule

// File: rtl/tmr_majority.sv
module tmr_majority
  import tmr_vote_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = vote_bit(a[i], b[i], c[i]);
  end
endmodule

// File: rtl/tmr_fault_decode.sv
module tmr_fault_decode
  import tmr_vote_pkg::*;
(
  input  logic [2:0] flags,
  output logic [2:0] bad_module,
  output logic [2:0] bad_cmp,
  output logic       multi_err
);
  diag_class_e cls;
  assign cls = classify(flags);

  always_comb begin
    bad_module = '0;
    bad_cmp    = '0;
    multi_err  = 1'b0;
    unique case (cls)
      DX_MODULE: bad_module = odd_module(flags);
      DX_COMPAR: bad_cmp    = flags;
      DX_MULTI:  multi_err  = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/tmr_voter_diag.sv
module tmr_voter_diag
  import tmr_vote_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] mod_a,
  input  logic [W-1:0] mod_b,
  input  logic [W-1:0] mod_c,
  output logic         out_valid,
  output logic [W-1:0] voted,
  output logic [2:0]   mismatch,
  output logic [2:0]   bad_module,
  output logic [2:0]   bad_cmp,
  output logic         multi_err
);
  localparam int unsigned NPAIR = 3;
  localparam int unsigned LHS [NPAIR] = '{MOD_A, MOD_A, MOD_B};
  localparam int unsigned RHS [NPAIR] = '{MOD_B, MOD_C, MOD_C};

  logic [W-1:0] words [NUM_MOD];
  assign words[MOD_A] = mod_a;
  assign words[MOD_B] = mod_b;
  assign words[MOD_C] = mod_c;

  // Named combinational events feeding the registers
  logic [NPAIR-1:0] cmp_flags;
  logic [W-1:0]     vote_word;
  logic [2:0]       dec_module;
  logic [2:0]       dec_cmp;
  logic             dec_multi;

  for (genvar g = 0; g < NPAIR; g++) begin : g_cmp
    tmr_pair_cmp #(.W(W)) u_cmp (
      .x      (words[LHS[g]]),
      .y      (words[RHS[g]]),
      .differ (cmp_flags[g])
    );
  end

  tmr_majority #(.W(W)) u_vote (
    .a (mod_a),
    .b (mod_b),
    .c (mod_c),
    .y (vote_word)
  );

  tmr_fault_decode u_dec (
    .flags      (cmp_flags),
    .bad_module (dec_module),
    .bad_cmp    (dec_cmp),
    .multi_err  (dec_multi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      voted      <= '0;
      mismatch   <= '0;
      bad_module <= '0;
      bad_cmp    <= '0;
      multi_err  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        voted      <= vote_word;
        mismatch   <= cmp_flags;
        bad_module <= dec_module;
        bad_cmp    <= dec_cmp;
        multi_err  <= dec_multi;
      end
    end
  end

  // R7
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(voted) && $stable(mismatch) && $stable(bad_module)
                   && $stable(bad_cmp) && $stable(multi_err)));
  // R10
  module_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bad_module));
  // R10
  class_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({|bad_module, |bad_cmp, multi_err}) <= 1);
  // R2
  agree_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mod_a == mod_b) |=> voted == $past(mod_a));
  // R5
  multi_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (&mismatch)) |-> (multi_err && bad_module == 3'b000));
  // R3
  blame_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (|bad_module) |-> ($countones(mismatch) == 2));
  // R6
  clean_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mismatch == 3'b000) |->
      (bad_module == 3'b000 && bad_cmp == 3'b000 && !multi_err));
endmodule

// File: tb/tmr_voter_diag_bench.sv
module tmr_voter_diag_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] mod_a = '0, mod_b = '0, mod_c = '0;
  logic         out_valid;
  logic [W-1:0] voted;
  logic [2:0]   mismatch, bad_module, bad_cmp;
  logic         multi_err;

  logic [2:0] d_flags = '0;
  logic [2:0] d_mod, d_cmp;
  logic       d_multi;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_voter_diag #(.W(W)) u_tmr_voter_diag (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .mod_a(mod_a), .mod_b(mod_b), .mod_c(mod_c),
    .out_valid(out_valid), .voted(voted), .mismatch(mismatch),
    .bad_module(bad_module), .bad_cmp(bad_cmp), .multi_err(multi_err)
  );

  tmr_fault_decode u_dec_alone (
    .flags(d_flags), .bad_module(d_mod), .bad_cmp(d_cmp), .multi_err(d_multi)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Per-bit count of ones, majority when two or more
  function automatic logic [W-1:0] ref_vote(input logic [W-1:0] a, b, c);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      int n;
      n = int'(a[i]) + int'(b[i]) + int'(c[i]);
      r[i] = (n >= 2);
    end
    return r;
  endfunction

  // Expected {multi, bad_cmp, bad_module} from data words
  function automatic logic [6:0] ref_diag(input logic [W-1:0] a, b, c);
    if (a == b && b == c) return 7'b0_000_000;
    if (b == c)           return 7'b0_000_001;
    if (a == c)           return 7'b0_000_010;
    if (a == b)           return 7'b0_000_100;
    return 7'b1_000_000;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] hv;
    logic [2:0]   hm, hb, hc;
    logic         hx;
    // R9: reset state
    repeat (3) @(negedge clk);
    check({out_valid, voted, mismatch, bad_module, bad_cmp, multi_err} == '0,
          "R9", "reset outputs",
          32'({out_valid, voted, mismatch, bad_module, bad_cmp, multi_err}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "idle after reset", 32'(out_valid), 0);

    // Exhaustive sweep of three 4-bit words, back to back
    for (int i = 0; i < (1 << (3 * W)); i++) begin
      logic [W-1:0] a, b, c;
      logic [2:0]   em;
      logic [6:0]   ed;
      a = i[W-1:0]; b = i[2*W-1:W]; c = i[3*W-1:2*W];
      mod_a = a; mod_b = b; mod_c = c; in_valid = 1'b1;
      @(negedge clk);
      em = {b != c, a != c, a != b};
      ed = ref_diag(a, b, c);
      check(out_valid == 1'b1, "R7", "out_valid after strobe", 32'(out_valid), 1);
      check(voted == ref_vote(a, b, c), "R2", "voted", 32'(voted), 32'(ref_vote(a, b, c)));
      check(mismatch == em, "R1", "mismatch", 32'(mismatch), 32'(em));
      if (ed == 7'b0)
        check({multi_err, bad_cmp, bad_module} == 7'b0 && voted == a, "R6",
              "clean diag", 32'({multi_err, bad_cmp, bad_module}), 0);
      else if (ed[6])
        check({multi_err, bad_cmp, bad_module} == ed, "R5", "multi diag",
              32'({multi_err, bad_cmp, bad_module}), 32'(ed));
      else
        check({multi_err, bad_cmp, bad_module} == ed, "R3", "module diag",
              32'({multi_err, bad_cmp, bad_module}), 32'(ed));
      check($onehot0(bad_module) &&
            (int'(|bad_module) + int'(|bad_cmp) + int'(multi_err)) <= 1,
            "R10", "exclusive classes", 32'({multi_err, bad_cmp, bad_module}), 0);
    end

    // R8: hold a module-fault result across idle cycles with changing data
    mod_a = 4'h5; mod_b = 4'h9; mod_c = 4'h9; in_valid = 1'b1;
    @(negedge clk);
    hv = voted; hm = mismatch; hb = bad_module; hc = bad_cmp; hx = multi_err;
    check(hb == 3'b001, "R3", "A blamed before hold", 32'(hb), 1);
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      mod_a = 4'(k); mod_b = 4'(k + 7); mod_c = 4'(k + 11);
      @(negedge clk);
      check(out_valid == 1'b0, "R8", "out_valid idle", 32'(out_valid), 0);
      check({voted, mismatch, bad_module, bad_cmp, hx} == {hv, hm, hb, hc, multi_err},
            "R8", "results held", 32'({voted, mismatch, bad_module, bad_cmp}),
            32'({hv, hm, hb, hc}));
    end

    // R9: reset in the middle of a faulty result
    mod_a = 4'h1; mod_b = 4'h2; mod_c = 4'h4; in_valid = 1'b1;
    @(negedge clk);
    check(multi_err == 1'b1, "R5", "multi before reset", 32'(multi_err), 1);
    rst = 1'b1;
    @(negedge clk);
    check({out_valid, voted, mismatch, bad_module, bad_cmp, multi_err} == '0,
          "R9", "reset clears", 32'({voted, mismatch, bad_module, bad_cmp, multi_err}), 0);
    rst = 1'b0; in_valid = 1'b0;

    // Diagnosis unit alone over all eight flag patterns
    for (int p = 0; p < 8; p++) begin
      logic [2:0] f, xm, xc;
      logic       xx;
      f = 3'(p);
      d_flags = f;
      #1;
      xm = 3'b000; xc = 3'b000; xx = 1'b0;
      case (int'(f[0]) + int'(f[1]) + int'(f[2]))
        1: xc = f;
        2: xm = (f == 3'b011) ? 3'b001 : (f == 3'b101) ? 3'b010 : 3'b100;
        3: xx = 1'b1;
        default: ;
      endcase
      if (int'(f[0]) + int'(f[1]) + int'(f[2]) == 1)
        check({d_multi, d_cmp, d_mod} == {xx, xc, xm}, "R4", "comparator fault",
              32'({d_multi, d_cmp, d_mod}), 32'({xx, xc, xm}));
      else
        check({d_multi, d_cmp, d_mod} == {xx, xc, xm}, "R10", "decode pattern",
              32'({d_multi, d_cmp, d_mod}), 32'({xx, xc, xm}));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule